// File: doc/BRIEF.md
# Tagged memory reference walker

This block carries out the memory side of a tagged stack machine's fetch, load and store operations. Every memory word holds 48 data bits and a 3-bit tag, and the tag decides what the walker does with the word. A value fetch that lands on a reference word (tag 1) takes that word's low address bits as the next address and reads again, until it reaches a plain data word. If the fetch lands on a procedure word (tag 7), the walker raises a procedure-entry request and waits for the caller to report the return value.

A store first reads its target. An odd tag on the target marks it read-only. In that case a protected store raises a memory-protect interrupt and leaves memory unchanged, while the overwrite variants write anyway. The destructive and non-destructive forms differ only in a `keep` flag, which tells the surrounding stack logic whether the stored value stays on the stack.

Chain length is capped by a programmable limit, clamped to 16 hops, so a reference loop ends with an error flag and cannot hang the block. The memory port is synchronous: read data appears the cycle after the request. Translation from address couple to absolute address happens elsewhere.

Top module: `tagref_walker`

## Requirements
- R1: During and directly after reset, `busy`, `done`, `proc_entry` and `mem_en` are low.
- R2: Operation code 1 (name) completes at the first rising edge, counting the accepting edge as the first. It returns the request address zero-extended with tag 1 and makes no memory access.
- R3: Operation code 0 (value fetch) that reads a word whose tag is neither 1 nor 7 returns that word and its tag. `done` is high for exactly one cycle, after the third rising edge.
- R4: When a fetch or load reads a tag-1 word, its low address bits become the next read address. Each hop adds two cycles.
- R5: A value fetch that reads a tag-7 word holds `proc_entry` high, without `done`, until `call_ret` is seen. `done` then follows on the next edge, carrying `ret_value` and `ret_tag`.
- R6: Operation code 2 (load) takes its start address from the low bits of `req_value` and accepts only `req_vtag` 1 or 5. Any other tag ends at the first edge with `err` and no memory access. A tag-7 word met by a load is returned as data.
- R7: The hop limit is the smaller of `max_depth` and 16. Reading a tag-1 word after that many hops ends with `err`, result 0 and tag 0. `err`, `protect_irq` and `proc_entry` are never high together.
- R8: Codes 4 and 5 (protected stores) whose target tag is odd raise `protect_irq` together with `done` after the third edge, and do not write memory.
- R9: A permitted store writes `req_value` with `req_vtag` unchanged, then signals `done` after the fourth edge, echoing the value and tag.
- R10: `keep` is high with `done` for store codes 5 and 7, and low for codes 4 and 6.
- R11: Overwrite codes 6 and 7 write regardless of the target's tag.
- R12: Code 3 is reserved. It completes at the first edge with `err` set.
- R13: A request raised while the block is busy is ignored and produces no extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Start or target address |
| req_value | input | 48 | Store value, or address word for load |
| req_vtag | input | 3 | Tag of `req_value` |
| max_depth | input | CW | Programmable hop limit |
| call_ret | input | 1 | Procedure returned |
| ret_value | input | 48 | Value returned by the procedure |
| ret_tag | input | 3 | Tag of the returned value |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 48 | Write data |
| mem_wtag | output | 3 | Write tag |
| mem_rdata | input | 48 | Read data, one cycle after the read request |
| mem_rtag | input | 3 | Read tag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 48 | Result value |
| result_tag | output | 3 | Result tag |
| keep | output | 1 | Stored value stays on stack |
| proc_entry | output | 1 | Procedure entry request |
| protect_irq | output | 1 | Memory-protect interrupt |
| err | output | 1 | Bad chain, bad address tag or reserved code |

## Verification
The latency of each operation follows from the number of reads it makes. A name or reserved request completes after 1 edge and a direct fetch after 3. Each hop adds 2 edges, and a granted store takes 4. The bench counts rising edges from the accepting edge up to the first falling edge that shows `done`, and compares that count with the vector's expected latency. Results are sampled only at that falling edge, when every output is settled. The procedure case is driven by hand: `proc_entry` is checked over several idle cycles before `call_ret` is raised, and `done` is checked one edge later.

// File: rtl/tagref_pkg.sv
`timescale 1ns/1ps
package tagref_pkg;
    localparam int DATA_W = 48;
    localparam int TAG_W  = 3;

    localparam logic [TAG_W-1:0] TAG_REF  = 3'd1;
    localparam logic [TAG_W-1:0] TAG_DESC = 3'd5;
    localparam logic [TAG_W-1:0] TAG_PROC = 3'd7;

    typedef enum logic [2:0] {
        OP_VALUE = 3'd0,
        OP_NAME  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_RSVD  = 3'd3,
        OP_STD   = 3'd4,
        OP_STN   = 3'd5,
        OP_OVD   = 3'd6,
        OP_OVN   = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_EXAM  = 3'd2,
        ST_WRITE = 3'd3,
        ST_CALL  = 3'd4,
        ST_DONE  = 3'd5
    } state_e;
endpackage

// File: rtl/tagref_tag_class.sv
`timescale 1ns/1ps
module tagref_tag_class
    import tagref_pkg::*;
(
    input  logic [TAG_W-1:0] tag,
    output logic             is_ref,
    output logic             is_proc,
    output logic             is_odd
);
    // Classification of a word read back from memory
    assign is_ref  = (tag == TAG_REF);
    assign is_proc = (tag == TAG_PROC);
    assign is_odd  = tag[0];
endmodule

// File: rtl/tagref_chain_guard.sv
`timescale 1ns/1ps
module tagref_chain_guard #(
    parameter int MAX_HOPS = 16,
    parameter int CW       = 5
) (
    input  logic [CW-1:0] hops,
    input  logic [CW-1:0] limit,
    output logic          exhausted
);
    localparam logic [CW-1:0] CAP = CW'(MAX_HOPS);

    logic [CW-1:0] eff_limit;

    // The programmed limit can never exceed the hard cap
    assign eff_limit = (limit > CAP) ? CAP : limit;
    assign exhausted = (hops >= eff_limit);
endmodule

// File: rtl/tagref_store_policy.sv
`timescale 1ns/1ps
module tagref_store_policy
    import tagref_pkg::*;
(
    input  op_e  op,
    input  logic target_odd,
    output logic is_store,
    output logic keep_val,
    output logic blocked
);
    logic [2:0] code;
    logic       overwrite;

    // Code bit 2 marks a store, bit 1 an overwrite, bit 0 a non-destructive form
    assign code      = op;
    assign is_store  = code[2];
    assign overwrite = code[1];
    assign keep_val  = code[0];
    assign blocked   = is_store && !overwrite && target_odd;
endmodule

// File: rtl/tagref_walker.sv
`timescale 1ns/1ps
module tagref_walker
    import tagref_pkg::*;
#(
    parameter  int AW       = 6,
    parameter  int MAX_HOPS = 16,
    localparam int CW       = $clog2(MAX_HOPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_value,
    input  logic [TAG_W-1:0]  req_vtag,
    input  logic [CW-1:0]     max_depth,
    input  logic              call_ret,
    input  logic [DATA_W-1:0] ret_value,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [TAG_W-1:0]  mem_wtag,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [TAG_W-1:0]  mem_rtag,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [TAG_W-1:0]  result_tag,
    output logic              keep,
    output logic              proc_entry,
    output logic              protect_irq,
    output logic              err
);
    typedef struct packed {
        state_e             st;
        op_e                op;
        logic [AW-1:0]      addr;
        logic [DATA_W-1:0]  val;
        logic [TAG_W-1:0]   vtag;
        logic [CW-1:0]      hops;
        logic [CW-1:0]      lim;
        logic [DATA_W-1:0]  res;
        logic [TAG_W-1:0]   rtag;
        logic               keep;
        logic               prot;
        logic               err;
    } walk_t;

    walk_t q, d;

    logic rd_ref, rd_proc, rd_odd;
    logic chain_full;
    logic st_store, st_keep, st_blocked;
    logic load_tag_ok;

    tagref_tag_class u_class (
        .tag     (mem_rtag),
        .is_ref  (rd_ref),
        .is_proc (rd_proc),
        .is_odd  (rd_odd)
    );

    tagref_chain_guard #(
        .MAX_HOPS (MAX_HOPS),
        .CW       (CW)
    ) u_guard (
        .hops      (q.hops),
        .limit     (q.lim),
        .exhausted (chain_full)
    );

    tagref_store_policy u_policy (
        .op         (q.op),
        .target_odd (rd_odd),
        .is_store   (st_store),
        .keep_val   (st_keep),
        .blocked    (st_blocked)
    );

    assign load_tag_ok = (req_vtag == TAG_REF) || (req_vtag == TAG_DESC);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op   = op_e'(req_op);
                    d.addr = req_addr;
                    d.val  = req_value;
                    d.vtag = req_vtag;
                    d.hops = '0;
                    d.lim  = max_depth;
                    d.res  = '0;
                    d.rtag = '0;
                    d.keep = 1'b0;
                    d.prot = 1'b0;
                    d.err  = 1'b0;
                    unique case (op_e'(req_op))
                        OP_NAME: begin
                            d.res  = {{(DATA_W-AW){1'b0}}, req_addr};
                            d.rtag = TAG_REF;
                            d.st   = ST_DONE;
                        end
                        OP_RSVD: begin
                            d.err = 1'b1;
                            d.st  = ST_DONE;
                        end
                        OP_LOAD: begin
                            if (load_tag_ok) begin
                                d.addr = req_value[AW-1:0];
                                d.st   = ST_READ;
                            end else begin
                                d.err = 1'b1;
                                d.st  = ST_DONE;
                            end
                        end
                        default: d.st = ST_READ;
                    endcase
                end
            end
            ST_READ: d.st = ST_EXAM;
            ST_EXAM: begin
                if (st_store) begin
                    if (st_blocked) begin
                        d.prot = 1'b1;
                        d.st   = ST_DONE;
                    end else begin
                        d.st = ST_WRITE;
                    end
                end else if (rd_ref) begin
                    if (chain_full) begin
                        d.err = 1'b1;
                        d.st  = ST_DONE;
                    end else begin
                        d.addr = mem_rdata[AW-1:0];
                        d.hops = q.hops + 1'b1;
                        d.st   = ST_READ;
                    end
                end else if (rd_proc && (q.op == OP_VALUE)) begin
                    d.st = ST_CALL;
                end else begin
                    d.res  = mem_rdata;
                    d.rtag = mem_rtag;
                    d.st   = ST_DONE;
                end
            end
            ST_WRITE: begin
                d.res  = q.val;
                d.rtag = q.vtag;
                d.keep = st_keep;
                d.st   = ST_DONE;
            end
            ST_CALL: begin
                if (call_ret) begin
                    d.res  = ret_value;
                    d.rtag = ret_tag;
                    d.st   = ST_DONE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_en      = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we      = (q.st == ST_WRITE);
    assign mem_addr    = q.addr;
    assign mem_wdata   = q.val;
    assign mem_wtag    = q.vtag;
    assign busy        = (q.st != ST_IDLE);
    assign done        = (q.st == ST_DONE);
    assign result      = q.res;
    assign result_tag  = q.rtag;
    assign keep        = done && q.keep;
    assign proc_entry  = (q.st == ST_CALL);
    assign protect_irq = done && q.prot;
    assign err         = done && q.err;
endmodule

// File: rtl/tagref_walker_chk.sv
`timescale 1ns/1ps
module tagref_walker_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mem_en,
    input logic mem_we,
    input logic proc_entry,
    input logic call_ret,
    input logic protect_irq,
    input logic err
);
    // R1
    idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // R13
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);

    // R9
    write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);

    // R5
    call_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_entry && !call_ret) |=> (proc_entry && !done));

    // R5
    call_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_entry && call_ret) |=> (done && !proc_entry));

    // R8
    protect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        protect_irq |-> (done && !$past(mem_we)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({protect_irq, err, proc_entry}));
endmodule

bind tagref_walker tagref_walker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .proc_entry  (proc_entry),
    .call_ret    (call_ret),
    .protect_irq (protect_irq),
    .err         (err)
);

// File: tb/sim_tagref_walker.sv
`timescale 1ns/1ps
module sim_tagref_walker;
    localparam int AW = 6;
    localparam int CW = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [AW-1:0]     req_addr = '0;
    logic [47:0]       req_value = '0;
    logic [2:0]        req_vtag = '0;
    logic [CW-1:0]     max_depth = 5'd16;
    logic              call_ret = 1'b0;
    logic [47:0]       ret_value = '0;
    logic [2:0]        ret_tag = '0;
    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [47:0]       mem_wdata;
    logic [2:0]        mem_wtag;
    logic [47:0]       mem_rdata;
    logic [2:0]        mem_rtag;
    logic              busy, done, keep, proc_entry, protect_irq, err;
    logic [47:0]       result;
    logic [2:0]        result_tag;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;

    always #10 clk = ~clk;

    tagref_walker #(.AW(AW), .MAX_HOPS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_value(req_value), .req_vtag(req_vtag),
        .max_depth(max_depth), .call_ret(call_ret), .ret_value(ret_value),
        .ret_tag(ret_tag), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wtag(mem_wtag), .mem_rdata(mem_rdata),
        .mem_rtag(mem_rtag), .busy(busy), .done(done), .result(result),
        .result_tag(result_tag), .keep(keep), .proc_entry(proc_entry),
        .protect_irq(protect_irq), .err(err)
    );

    // Synchronous tagged memory model
    logic [47:0] mdata [64];
    logic [2:0]  mtag  [64];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mdata[mem_addr] <= mem_wdata;
                mtag[mem_addr]  <= mem_wtag;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mdata[mem_addr];
                mem_rtag  <= mtag[mem_addr];
            end
        end
    end

    typedef struct packed {
        logic [3:0]  rq;
        logic [2:0]  op;
        logic [5:0]  addr;
        logic [47:0] val;
        logic [2:0]  vtag;
        logic [4:0]  md;
        logic [47:0] res;
        logic [2:0]  rtag;
        logic        kp;
        logic        prot;
        logic        er;
        logic [7:0]  cyc;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  3'd1, 6'd42, 48'h0,    3'd0, 5'd16, 48'h2A,   3'd1, 1'b0, 1'b0, 1'b0, 8'd1},
        '{4'd3,  3'd0, 6'd10, 48'h0,    3'd0, 5'd16, 48'h1234, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd4,  3'd0, 6'd11, 48'h0,    3'd0, 5'd16, 48'h1234, 3'd0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{4'd4,  3'd0, 6'd12, 48'h0,    3'd0, 5'd16, 48'h1234, 3'd0, 1'b0, 1'b0, 1'b0, 8'd7},
        '{4'd3,  3'd0, 6'd13, 48'h0,    3'd0, 5'd16, 48'hABCD, 3'd2, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd6,  3'd2, 6'd0,  48'd12,   3'd1, 5'd16, 48'h1234, 3'd0, 1'b0, 1'b0, 1'b0, 8'd7},
        '{4'd6,  3'd2, 6'd0,  48'd16,   3'd5, 5'd16, 48'h777,  3'd7, 1'b0, 1'b0, 1'b0, 8'd5},
        '{4'd6,  3'd2, 6'd0,  48'd10,   3'd0, 5'd16, 48'h0,    3'd0, 1'b0, 1'b0, 1'b1, 8'd1},
        '{4'd9,  3'd4, 6'd20, 48'hCAFE, 3'd2, 5'd16, 48'hCAFE, 3'd2, 1'b0, 1'b0, 1'b0, 8'd4},
        '{4'd9,  3'd0, 6'd20, 48'h0,    3'd0, 5'd16, 48'hCAFE, 3'd2, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd10, 3'd5, 6'd23, 48'hBEEF, 3'd0, 5'd16, 48'hBEEF, 3'd0, 1'b1, 1'b0, 1'b0, 8'd4},
        '{4'd8,  3'd4, 6'd21, 48'h1,    3'd0, 5'd16, 48'h0,    3'd0, 1'b0, 1'b1, 1'b0, 8'd3},
        '{4'd8,  3'd0, 6'd21, 48'h0,    3'd0, 5'd16, 48'h99,   3'd3, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd8,  3'd5, 6'd22, 48'h2,    3'd0, 5'd16, 48'h0,    3'd0, 1'b0, 1'b1, 1'b0, 8'd3},
        '{4'd11, 3'd6, 6'd21, 48'h4242, 3'd0, 5'd16, 48'h4242, 3'd0, 1'b0, 1'b0, 1'b0, 8'd4},
        '{4'd11, 3'd0, 6'd21, 48'h0,    3'd0, 5'd16, 48'h4242, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd10, 3'd7, 6'd22, 48'h5151, 3'd6, 5'd16, 48'h5151, 3'd6, 1'b1, 1'b0, 1'b0, 8'd4},
        '{4'd11, 3'd0, 6'd22, 48'h0,    3'd0, 5'd16, 48'h5151, 3'd6, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd12, 3'd3, 6'd0,  48'h0,    3'd0, 5'd16, 48'h0,    3'd0, 1'b0, 1'b0, 1'b1, 8'd1},
        '{4'd7,  3'd0, 6'd15, 48'h0,    3'd0, 5'd16, 48'h0,    3'd0, 1'b0, 1'b0, 1'b1, 8'd35},
        '{4'd7,  3'd0, 6'd12, 48'h0,    3'd0, 5'd1,  48'h0,    3'd0, 1'b0, 1'b0, 1'b1, 8'd5},
        '{4'd4,  3'd0, 6'd12, 48'h0,    3'd0, 5'd2,  48'h1234, 3'd0, 1'b0, 1'b0, 1'b0, 8'd7},
        '{4'd7,  3'd0, 6'd15, 48'h0,    3'd0, 5'd20, 48'h0,    3'd0, 1'b0, 1'b0, 1'b1, 8'd35},
        '{4'd3,  3'd0, 6'd10, 48'h0,    3'd0, 5'd0,  48'h1234, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3},
        '{4'd7,  3'd0, 6'd11, 48'h0,    3'd0, 5'd0,  48'h0,    3'd0, 1'b0, 1'b0, 1'b1, 8'd3},
        '{4'd10, 3'd0, 6'd23, 48'h0,    3'd0, 5'd16, 48'hBEEF, 3'd0, 1'b0, 1'b0, 1'b0, 8'd3}
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            4'd12: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Drive one request and count edges until done is seen at a falling edge
    task automatic issue(input vec_t v, output int cyc);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = v.op;
        req_addr  = v.addr;
        req_value = v.val;
        req_vtag  = v.vtag;
        max_depth = v.md;
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mdata[i] = '0;
            mtag[i]  = '0;
        end
        mdata[10] = 48'h1234; mtag[10] = 3'd0;
        mdata[11] = 48'd10;   mtag[11] = 3'd1;
        mdata[12] = 48'd11;   mtag[12] = 3'd1;
        mdata[13] = 48'hABCD; mtag[13] = 3'd2;
        mdata[14] = 48'h777;  mtag[14] = 3'd7;
        mdata[15] = 48'd15;   mtag[15] = 3'd1;
        mdata[16] = 48'd14;   mtag[16] = 3'd1;
        mdata[20] = 48'h55;   mtag[20] = 3'd0;
        mdata[21] = 48'h99;   mtag[21] = 3'd3;
        mdata[22] = 48'h66;   mtag[22] = 3'd5;
        mdata[23] = 48'h0;    mtag[23] = 3'd0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !proc_entry && !mem_en, "R1", "in reset",
            {busy, done, proc_entry, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !proc_entry && !mem_en, "R1", "after reset",
            {busy, done, proc_entry, mem_en}, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            int    cyc;
            int    w0;
            string rq;
            rq = rname(VECS[i].rq);
            w0 = wr_cnt;
            issue(VECS[i], cyc);
            chk(cyc == int'(VECS[i].cyc), rq, "latency", cyc, VECS[i].cyc);
            chk(result == VECS[i].res, rq, "result", result, VECS[i].res);
            chk(result_tag == VECS[i].rtag, rq, "tag", result_tag, VECS[i].rtag);
            chk(keep == VECS[i].kp, rq, "keep", keep, VECS[i].kp);
            chk(protect_irq == VECS[i].prot, rq, "protect", protect_irq, VECS[i].prot);
            chk(err == VECS[i].er, rq, "err", err, VECS[i].er);
            if (VECS[i].prot || VECS[i].er || VECS[i].op == 3'd1)
                chk(wr_cnt == w0, rq, "no write", wr_cnt, w0);
        end

        // R5: procedure word held until return
        begin
            vec_t pv;
            int   cyc;
            pv = '0;
            pv.op = 3'd0; pv.addr = 6'd16; pv.md = 5'd16;
            @(negedge clk);
            req_valid = 1'b1; req_op = pv.op; req_addr = pv.addr; max_depth = pv.md;
            @(negedge clk);
            req_valid = 1'b0;
            cyc = 1;
            while (!proc_entry && cyc < 100) begin
                @(negedge clk);
                cyc++;
            end
            chk(cyc == 5, "R5", "entry latency", cyc, 5);
            repeat (4) @(negedge clk);
            chk(proc_entry && !done, "R5", "held", {proc_entry, done}, 2'b10);
            call_ret = 1'b1; ret_value = 48'h31337; ret_tag = 3'd2;
            @(negedge clk);
            call_ret = 1'b0;
            chk(done && !proc_entry, "R5", "released", {done, proc_entry}, 2'b10);
            chk(result == 48'h31337, "R5", "return value", result, 48'h31337);
            chk(result_tag == 3'd2, "R5", "return tag", result_tag, 3'd2);
        end

        // R13: request during busy is ignored
        begin
            int cyc;
            int dones;
            @(negedge clk);
            req_valid = 1'b1; req_op = 3'd0; req_addr = 6'd12; max_depth = 5'd16;
            @(negedge clk);
            req_valid = 1'b0;
            cyc = 1;
            @(negedge clk);
            cyc++;
            req_valid = 1'b1; req_op = 3'd1; req_addr = 6'd5;
            @(negedge clk);
            cyc++;
            req_valid = 1'b0;
            while (!done && cyc < 100) begin
                @(negedge clk);
                cyc++;
            end
            chk(cyc == 7, "R13", "latency", cyc, 7);
            chk(result == 48'h1234, "R13", "result", result, 48'h1234);
            dones = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (done || busy) dones++;
            end
            chk(dones == 0, "R13", "extra activity", dones, 0);
        end

        finish_run();
    end
endmodule